// File: doc/BRIEF.md
# Virtual Interface Maintenance Interrupt Controller

This block holds the hypervisor's 32-bit control word for a virtual interrupt CPU interface. From that word and a few live status inputs it produces one maintenance interrupt toward the hypervisor. The status inputs are the valid bit and 2-bit state of each list register, and the two virtual group enables. It also drives the global enable that switches the whole virtual interface on or off.

A hypervisor writes the control word through a simple write port and can read it back at any time. A miss counter in the top five bits of the word counts each end-of-interrupt or deactivate event that should have retired a virtual interrupt but found no list register for it. Software can therefore keep more interrupts active than there are list registers, and it is told through the maintenance line while the count is non-zero. The five trap control bits are stored and read back here; other logic acts on them.

Top module: `vmi_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, `maint_irq` is 0 and `vif_enable` is 0.
- R2: Bits [26:15] and [9:8] of the control word always read 0 and ignore writes. Bits [31:27], [14:10] and [7:0] read back the last value written.
- R3: The miss counter in bits [31:27] increments by one when an event has `deact_is_dir`=0 (end-of-interrupt write), `deact_mode`=0, `deact_id` < 8192 and `deact_no_lr`=1.
- R4: The counter also increments when an event has `deact_is_dir`=1 (deactivate write), `deact_mode`=1, `deact_id` < 8192 and `deact_no_lr`=1. Any other combination leaves the counter unchanged.
- R5: The counter wraps from 31 to 0. A write to the control word loads the counter from bits [31:27] of the written data, and this load wins over an increment in the same cycle.
- R6: The missed-entry source (bit 2 set) is active while the counter is non-zero.
- R7: The underflow source (bit 1 set) is active while at most one `lr_valid` bit is 1.
- R8: The no-pending source (bit 3 set) is active while no list register has state 2'b01 (pending). Entry i's state is `lr_state[2i+1:2i]`.
- R9: The group sources are active under these conditions: bit 4 while `vgrp0_en`=1, bit 5 while `vgrp0_en`=0, bit 6 while `vgrp1_en`=1, and bit 7 while `vgrp1_en`=0.
- R10: `vif_enable` equals bit 0 of the control word. While bit 0 is 0, `maint_irq` stays 0 whatever the sources are.
- R11: `maint_irq` is the OR of all active sources, gated by bit 0, and taken through one register. It changes one clock edge after the state and inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current control word |
| deact_valid | input | 1 | Retire event strobe, one cycle per event |
| deact_is_dir | input | 1 | 0 = end-of-interrupt write, 1 = deactivate write |
| deact_mode | input | 1 | Current EOI mode of the virtual interface |
| deact_id | input | ID_W | Interrupt ID carried by the event |
| deact_no_lr | input | 1 | 1 when no list register matched the ID |
| lr_valid | input | NUM_LR | Valid bit of each list register |
| lr_state | input | 2*NUM_LR | State of each list register, 2 bits per entry |
| vgrp0_en | input | 1 | Virtual group 0 enable |
| vgrp1_en | input | 1 | Virtual group 1 enable |
| maint_irq | output | 1 | Registered maintenance interrupt |
| vif_enable | output | 1 | Global virtual-interface enable |

## Verification
The properties assume every input is a known value from the first edge after reset. They also assume a retire event lasts exactly one cycle per `deact_valid` pulse, and that the event qualifiers are meaningful only while the strobe is high. The stimulus changes inputs only on the falling edge and holds them steady across the two rising edges a result needs. For this reason each expected level depends on one settled set of status inputs. Retire events are never issued back to back, except for the one case where an event and a write deliberately share a cycle.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
   localparam int REG_W  = 32;
   localparam int CNT_LSB = 27;
   localparam int CNT_W  = 5;

   localparam int B_EN    = 0;
   localparam int B_UNDER = 1;
   localparam int B_MISS  = 2;
   localparam int B_NOPND = 3;
   localparam int B_G0ON  = 4;
   localparam int B_G0OFF = 5;
   localparam int B_G1ON  = 6;
   localparam int B_G1OFF = 7;

   // writable bits: counter [31:27], traps [14:10], enables [7:0]
   localparam logic [REG_W-1:0] RW_MASK = 32'hF800_7CFF;

   localparam logic [1:0] ST_PENDING = 2'b01;

   typedef struct packed {
      logic g1_off;
      logic g1_on;
      logic g0_off;
      logic g0_on;
      logic no_pend;
      logic miss;
      logic under;
   } src_t;
endpackage

// File: rtl/vmi_cfg_reg.sv
module vmi_cfg_reg
   import vmi_pkg::*;
#(
   parameter int ID_W     = 24,
   parameter int ID_LIMIT = 8192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ev_valid,
   input  logic             ev_is_dir,
   input  logic             ev_mode,
   input  logic [ID_W-1:0]  ev_id,
   input  logic             ev_no_lr,
   output logic [REG_W-1:0] reg_q
);
   localparam logic [ID_W:0] LIMIT_V = ID_LIMIT[ID_W:0];

   logic id_ok;
   logic mode_ok;
   logic miss_hit;

   // end-of-interrupt counts in mode 0, deactivate counts in mode 1
   assign id_ok    = ({1'b0, ev_id} < LIMIT_V);
   assign mode_ok  = (ev_is_dir == ev_mode);
   assign miss_hit = ev_valid & id_ok & mode_ok & ev_no_lr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (wr_en) begin
         reg_q <= wr_data & RW_MASK;
      end else if (miss_hit) begin
         reg_q[CNT_LSB +: CNT_W] <= reg_q[CNT_LSB +: CNT_W] + CNT_W'(1);
      end
   end
endmodule

// File: rtl/vmi_lr_scan.sv
module vmi_lr_scan
   import vmi_pkg::*;
#(
   parameter int NUM_LR = 4
) (
   input  logic [NUM_LR-1:0]   lr_valid,
   input  logic [2*NUM_LR-1:0] lr_state,
   output logic                any_pending,
   output logic                few_valid
);
   logic [NUM_LR-1:0] pend;

   for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
      assign pend[i] = (lr_state[2*i +: 2] == ST_PENDING);
   end

   assign any_pending = |pend;

   if (NUM_LR == 1) begin : g_single
      logic unused_v;
      assign unused_v  = lr_valid[0];
      assign few_valid = 1'b1;
   end else begin : g_multi
      // clearing the lowest set bit leaves zero iff at most one bit was set
      assign few_valid = ((lr_valid & (lr_valid - NUM_LR'(1))) == '0);
   end
endmodule

// File: rtl/vmi_src_eval.sv
module vmi_src_eval
   import vmi_pkg::*;
(
   input  logic [7:1] ena,
   input  logic       cnt_nz,
   input  logic       any_pending,
   input  logic       few_valid,
   input  logic       vgrp0_en,
   input  logic       vgrp1_en,
   output src_t       src
);
   always_comb begin
      src.under   = ena[B_UNDER] & few_valid;
      src.miss    = ena[B_MISS]  & cnt_nz;
      src.no_pend = ena[B_NOPND] & ~any_pending;
      src.g0_on   = ena[B_G0ON]  &  vgrp0_en;
      src.g0_off  = ena[B_G0OFF] & ~vgrp0_en;
      src.g1_on   = ena[B_G1ON]  &  vgrp1_en;
      src.g1_off  = ena[B_G1OFF] & ~vgrp1_en;
   end
endmodule

// File: rtl/vmi_irq_out.sv
module vmi_irq_out
   import vmi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  src_t src,
   output logic irq_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= enable & (|src);
   end
endmodule

// File: rtl/vmi_ctrl.sv
module vmi_ctrl
   import vmi_pkg::*;
#(
   parameter int NUM_LR   = 4,
   parameter int ID_W     = 24,
   parameter int ID_LIMIT = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [31:0]         reg_wr_data,
   output logic [31:0]         reg_rd_data,
   input  logic                deact_valid,
   input  logic                deact_is_dir,
   input  logic                deact_mode,
   input  logic [ID_W-1:0]     deact_id,
   input  logic                deact_no_lr,
   input  logic [NUM_LR-1:0]   lr_valid,
   input  logic [2*NUM_LR-1:0] lr_state,
   input  logic                vgrp0_en,
   input  logic                vgrp1_en,
   output logic                maint_irq,
   output logic                vif_enable
);
   if (NUM_LR < 1 || NUM_LR > 16) begin : g_bad_lr
      $error("vmi_ctrl: NUM_LR must be 1..16");
   end
   if (ID_W < 1 || ID_W > 31) begin : g_bad_idw
      $error("vmi_ctrl: ID_W must be 1..31");
   end
   if (ID_LIMIT < 1 || ID_LIMIT > (1 << ID_W)) begin : g_bad_lim
      $error("vmi_ctrl: ID_LIMIT out of range for ID_W");
   end

   logic [REG_W-1:0] reg_q;
   logic             any_pending;
   logic             few_valid;
   logic             cnt_nz;
   src_t             src;

   vmi_cfg_reg #(.ID_W(ID_W), .ID_LIMIT(ID_LIMIT)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_data   (reg_wr_data),
      .ev_valid  (deact_valid),
      .ev_is_dir (deact_is_dir),
      .ev_mode   (deact_mode),
      .ev_id     (deact_id),
      .ev_no_lr  (deact_no_lr),
      .reg_q     (reg_q)
   );

   vmi_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
      .lr_valid    (lr_valid),
      .lr_state    (lr_state),
      .any_pending (any_pending),
      .few_valid   (few_valid)
   );

   assign cnt_nz = |reg_q[CNT_LSB +: CNT_W];

   vmi_src_eval u_src (
      .ena         (reg_q[7:1]),
      .cnt_nz      (cnt_nz),
      .any_pending (any_pending),
      .few_valid   (few_valid),
      .vgrp0_en    (vgrp0_en),
      .vgrp1_en    (vgrp1_en),
      .src         (src)
   );

   vmi_irq_out u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (reg_q[B_EN]),
      .src    (src),
      .irq_q  (maint_irq)
   );

   assign reg_rd_data = reg_q;
   assign vif_enable  = reg_q[B_EN];
endmodule

// File: rtl/vmi_ctrl_chk.sv
module vmi_ctrl_chk
   import vmi_pkg::*;
#(
   parameter int NUM_LR   = 4,
   parameter int ID_W     = 24,
   parameter int ID_LIMIT = 8192
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr_en,
   input logic [31:0]         reg_wr_data,
   input logic [31:0]         reg_rd_data,
   input logic                deact_valid,
   input logic                deact_is_dir,
   input logic                deact_mode,
   input logic [ID_W-1:0]     deact_id,
   input logic                deact_no_lr,
   input logic [NUM_LR-1:0]   lr_valid,
   input logic [2*NUM_LR-1:0] lr_state,
   input logic                vgrp0_en,
   input logic                vgrp1_en,
   input logic                maint_irq,
   input logic                vif_enable
);
   logic       hit;
   logic       pend_any;
   logic [4:0] cnt;

   assign cnt = reg_rd_data[31:27];
   assign hit = deact_valid && deact_no_lr && (deact_is_dir == deact_mode)
                && ({1'b0, deact_id} < ID_LIMIT[ID_W:0]);

   always_comb begin
      pend_any = 1'b0;
      for (int i = 0; i < NUM_LR; i++) begin
         if (lr_state[2*i +: 2] == ST_PENDING) pend_any = 1'b1;
      end
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[26:15] == '0) && (reg_rd_data[9:8] == '0)); // R2
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & RW_MASK)); // R5
   AST_MISS_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && hit) |=> cnt == $past(cnt) + 5'd1); // R3
   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && !hit) |=> $stable(reg_rd_data)); // R4
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vif_enable |=> !maint_irq); // R10
   AST_UNDER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (vif_enable && reg_rd_data[1] && $countones(lr_valid) <= 1) |=> maint_irq); // R7
   AST_MISS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (vif_enable && reg_rd_data[2] && cnt != 5'd0) |=> maint_irq); // R6
   AST_NOPEND_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (vif_enable && reg_rd_data[3] && !pend_any) |=> maint_irq); // R8
   AST_GROUP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (vif_enable && ((reg_rd_data[4] && vgrp0_en) || (reg_rd_data[5] && !vgrp0_en) ||
                      (reg_rd_data[6] && vgrp1_en) || (reg_rd_data[7] && !vgrp1_en)))
      |=> maint_irq); // R9
   AST_QUIET_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[7:1] == '0) |=> !maint_irq); // R11
endmodule

bind vmi_ctrl vmi_ctrl_chk #(.NUM_LR(NUM_LR), .ID_W(ID_W), .ID_LIMIT(ID_LIMIT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr_en    (reg_wr_en),
   .reg_wr_data  (reg_wr_data),
   .reg_rd_data  (reg_rd_data),
   .deact_valid  (deact_valid),
   .deact_is_dir (deact_is_dir),
   .deact_mode   (deact_mode),
   .deact_id     (deact_id),
   .deact_no_lr  (deact_no_lr),
   .lr_valid     (lr_valid),
   .lr_state     (lr_state),
   .vgrp0_en     (vgrp0_en),
   .vgrp1_en     (vgrp1_en),
   .maint_irq    (maint_irq),
   .vif_enable   (vif_enable)
);

// File: tb/sim_vmi_ctrl.sv
`timescale 1ns/1ps
module sim_vmi_ctrl;
   localparam int NLR  = 4;
   localparam int IDW  = 24;
   localparam logic [31:0] MASK = 32'hF800_7CFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr_en = 1'b0;
   logic [31:0]     reg_wr_data = '0;
   logic [31:0]     reg_rd_data;
   logic            deact_valid = 1'b0;
   logic            deact_is_dir = 1'b0;
   logic            deact_mode = 1'b0;
   logic [IDW-1:0]  deact_id = '0;
   logic            deact_no_lr = 1'b0;
   logic [NLR-1:0]  lr_valid = '0;
   logic [2*NLR-1:0] lr_state = '0;
   logic            vgrp0_en = 1'b0;
   logic            vgrp1_en = 1'b0;
   logic            maint_irq;
   logic            vif_enable;

   always #10 clk = ~clk;

   vmi_ctrl #(.NUM_LR(NLR), .ID_W(IDW), .ID_LIMIT(8192)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
      .deact_valid(deact_valid), .deact_is_dir(deact_is_dir), .deact_mode(deact_mode),
      .deact_id(deact_id), .deact_no_lr(deact_no_lr),
      .lr_valid(lr_valid), .lr_state(lr_state),
      .vgrp0_en(vgrp0_en), .vgrp1_en(vgrp1_en),
      .maint_irq(maint_irq), .vif_enable(vif_enable)
   );

   typedef struct {
      string       tag;
      int          kind;   // 0 word, 1 irq, 2 enable
      logic [31:0] exp;
   } item_t;

   item_t       sb[$];
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;
   logic [31:0] m_reg = '0;

   function automatic logic exp_irq();
      logic [7:0] e;
      bit anyp;
      int nv;
      e = m_reg[7:0];
      anyp = 1'b0;
      nv = 0;
      for (int i = 0; i < NLR; i++) begin
         if (lr_state[2*i +: 2] == 2'b01) anyp = 1'b1;
         if (lr_valid[i]) nv++;
      end
      return e[0] & ((e[7] & !vgrp1_en) | (e[6] & vgrp1_en) | (e[5] & !vgrp0_en) |
                     (e[4] & vgrp0_en) | (e[3] & !anyp) |
                     (e[2] & (m_reg[31:27] != 5'd0)) | (e[1] & (nv <= 1)));
   endfunction

   task automatic push(string tag, int kind, logic [31:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      sb.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag);
      tick();
      push(tag, 0, m_reg);
      push(tag, 1, {31'd0, exp_irq()});
      push(tag, 2, {31'd0, m_reg[0]});
   endtask

   task automatic wr(logic [31:0] v);
      reg_wr_en = 1'b1; reg_wr_data = v;
      tick();
      reg_wr_en = 1'b0;
      m_reg = v & MASK;
   endtask

   task automatic ev(bit is_dir, bit mode, int id, bit nolr);
      deact_valid = 1'b1; deact_is_dir = is_dir; deact_mode = mode;
      deact_id = IDW'(id); deact_no_lr = nolr;
      tick();
      deact_valid = 1'b0;
      if (nolr && (is_dir == mode) && id < 8192) m_reg[31:27] = m_reg[31:27] + 5'd1;
   endtask

   // monitor: compares queued expectations a little after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               0: act = reg_rd_data;
               1: act = {31'd0, maint_irq};
               default: act = {31'd0, vif_enable};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d: got %h expected %h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      // R1: reset state seen at the first falling edge after release
      push("R1", 0, 32'h0);
      push("R1", 1, 32'h0);
      push("R1", 2, 32'h0);
      tick();

      // R2: reserved bits masked on an all-ones write, then cleared
      wr(32'hFFFF_FFFF);
      chk("R2 all-ones");
      wr(32'h0000_0000);
      chk("R2 zero");

      // R11: output lags one edge behind the enabling write
      lr_valid = '0;
      wr(32'h0000_0003);
      push("R11 lag", 1, 32'h0);
      chk("R11 after");

      // R7 underflow with several valid patterns
      lr_valid = 4'b0011; chk("R7 two valid");
      lr_valid = 4'b0100; chk("R7 one valid");
      lr_valid = 4'b1111; chk("R7 all valid");
      lr_valid = 4'b0000; chk("R7 none valid");

      // R8 no-pending
      lr_valid = 4'b1111;
      wr(32'h0000_0009);
      lr_state = 8'b00_00_00_00; chk("R8 idle");
      lr_state = 8'b00_01_00_00; chk("R8 one pending");
      lr_state = 8'b11_10_11_10; chk("R8 active states");

      // R9 group sources, every bit against both levels of both enables
      for (int b = 4; b < 8; b++) begin
         wr(32'h1 | (32'h1 << b));
         for (int g = 0; g < 4; g++) begin
            vgrp0_en = g[0]; vgrp1_en = g[1];
            chk($sformatf("R9 bit%0d g=%0d", b, g));
         end
      end
      vgrp0_en = 1'b0; vgrp1_en = 1'b0;

      // R3/R4/R6 miss counter and its source
      wr(32'h0000_0005);
      chk("R6 zero count");
      ev(1'b0, 1'b0, 100, 1'b1);  chk("R3 eoi hit");
      ev(1'b1, 1'b1, 8191, 1'b1); chk("R4 dir hit");
      ev(1'b0, 1'b1, 5, 1'b1);    chk("R4 eoi wrong mode");
      ev(1'b1, 1'b0, 5, 1'b1);    chk("R4 dir wrong mode");
      ev(1'b0, 1'b0, 8192, 1'b1); chk("R4 id at limit");
      ev(1'b0, 1'b0, 5, 1'b0);    chk("R4 lr found");
      ev(1'b1, 1'b1, 0, 1'b1);    chk("R6 count three");

      // R5 wrap and write priority
      wr(32'hF800_0005);
      chk("R5 load 31");
      ev(1'b0, 1'b0, 7, 1'b1);    chk("R5 wrap");
      reg_wr_en = 1'b1; reg_wr_data = 32'h1000_0005;
      deact_valid = 1'b1; deact_is_dir = 1'b0; deact_mode = 1'b0;
      deact_id = IDW'(9); deact_no_lr = 1'b1;
      tick();
      reg_wr_en = 1'b0; deact_valid = 1'b0;
      m_reg = 32'h1000_0005 & MASK;
      chk("R5 write wins");

      // R10 global enable gates everything
      lr_valid = '0; lr_state = '0;
      wr(32'h0800_00FE);
      chk("R10 off");
      wr(32'h0800_00FF);
      chk("R10 on");

      repeat (3) tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule